// File: doc/BRIEF.md
# Serial Configuration Command Parser

This block sits behind a byte-wide receive path of a slow serial control link and turns short ASCII text commands into camera settings. Each command is one uppercase key letter, an equals sign, one or more decimal digits and a carriage return. The block checks the syntax and the value range for each key. An accepted value is written into a shadow settings bank, and each command is answered with a one-cycle accept or reject strobe. A separate apply pulse, raised by the readout sequencer when a frame readout ends, copies the whole shadow bank into the active bank that drives the rest of the imaging pipeline. A setting written during readout of frame N therefore takes effect for frame N+1. A setting written after that apply pulse waits for the next one.

The exclamation key selects special commands. Value 5 reloads factory settings into the shadow bank. Value 4 raises a store request for a non-volatile configuration keeper. Values 0 to 3 raise a readout request that carries the value, for a reply formatter elsewhere.

The parser is a five-state machine:
- `S_IDLE` waits for a key.
- `S_EQ` expects '='.
- `S_FIRST` expects the first digit.
- `S_DIGITS` accumulates further digits.
- `S_SKIP` discards bytes up to the next carriage return.

The transitions are these:
- `S_IDLE` goes to `S_EQ` on a known key and to `S_SKIP` on any other non-CR byte. A lone CR in `S_IDLE` is dropped.
- `S_EQ` goes to `S_FIRST` on '='.
- `S_FIRST` goes to `S_DIGITS` on a digit.
- `S_DIGITS` stays on a digit and returns to `S_IDLE` on CR, with the range verdict.
- A wrong byte in `S_EQ`, `S_FIRST` or `S_DIGITS` leads to `S_SKIP`.
- A CR in `S_EQ`, `S_FIRST` or `S_SKIP` returns to `S_IDLE` with a reject.

Top module: `cfg_cmd_parser`

## Requirements
- R1: A command made of a known uppercase key, '=' (0x3D), one or more decimal digits and CR (0x0D) pulses `cmd_ok` for one cycle in the cycle after the CR byte is taken. The known keys are T B G O S D A C M F I J K L and '!'. A byte is taken only in a cycle where `rx_valid` is high.
- R2: A command is rejected and `cmd_err` pulses once, in the cycle after its terminating CR, in any of these cases: it contains a space or a tab, it uses a lowercase or unknown key, the '=' is missing, or it has no digits. No setting changes, and the next command parses normally.
- R3: Values are range-checked per key, and a value outside its range is rejected with no setting change. The ranges are T 0..2, B 0..2, S 0..2, M 0..2, D 0..3, A 0..1, C 0..1, F 0..5, O 0..255, G 0..928, and I, J, K, L 1..2000.
- R4: Leading zeros are accepted. Digit accumulation saturates at 2^ACC_W-1, so an over-long number is rejected as out of range.
- R5: After reset both banks hold the factory settings: T=0 B=0 G=173 O=16 S=1 D=2 A=0 C=0 M=0 F=0 I=J=K=L=100.
- R6: Accepted writes change only the shadow bank, and the active outputs stay unchanged until `apply_pulse`. The active bank takes the shadow value as it stood at the apply edge. The shadow write lands one cycle after `cmd_ok`, so a write landing in the same cycle as an apply is seen only at the next apply.
- R7: `!=5` reloads the shadow bank with the factory settings and pulses `cmd_ok`. The active bank is untouched until the next apply.
- R8: `!=4` pulses `store_req` and `cmd_ok`. `!=0` to `!=3` pulse `query_req` with `query_sel` equal to the value, together with `cmd_ok`. `!=6` and above are rejected.
- R9: `cmd_ok` and `cmd_err` never pulse in the same cycle, and bytes presented while `rx_valid` is low have no effect.
- R10: A CR received with no command pending produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte valid this cycle |
| rx_byte | input | 8 | Received byte |
| apply_pulse | input | 1 | End-of-readout pulse: shadow to active |
| cmd_ok | output | 1 | Command accepted strobe |
| cmd_err | output | 1 | Command rejected strobe |
| store_req | output | 1 | Store-configuration request strobe |
| query_req | output | 1 | Readout request strobe |
| query_sel | output | 2 | Which readout is requested |
| cur_tmode | output | 2 | Active timing mode |
| cur_bin | output | 2 | Active binning mode |
| cur_gain | output | 10 | Active gain code |
| cur_ofs | output | 8 | Active offset code |
| cur_shut | output | 2 | Active shutter mode |
| cur_dly | output | 2 | Active shutter delay index |
| cur_abl | output | 1 | Active antiblooming select |
| cur_color | output | 1 | Active monochrome/three-shot select |
| cur_mode | output | 2 | Active video source select |
| cur_roi | output | 3 | Active masked-window count |
| cur_t_mono | output | 11 | Active monochrome exposure, ms |
| cur_t_red | output | 11 | Active red exposure, ms |
| cur_t_grn | output | 11 | Active green exposure, ms |
| cur_t_blu | output | 11 | Active blue exposure, ms |

## Verification
The bench builds the block with the default accumulator width of 12 bits. At that width the saturation ceiling of 4095 is reached by a five-digit number, which lets the bench exercise both the ordinary out-of-range reject and the saturating reject. Because the widths match the real field sizes, every range edge (928 and 929 for gain, 0, 1, 2000 and 3000 for exposure) falls inside the accumulator. The apply pulse is timed to coincide with a shadow write, so the one-frame deferral can be observed at the active outputs.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int GAIN_W = 10;
    localparam int OFS_W  = 8;
    localparam int TIME_W = 11;
    localparam int ROI_W  = 3;

    typedef enum logic [3:0] {
        K_TMODE, K_BIN, K_GAIN, K_OFS, K_SHUT, K_DLY, K_ABL, K_COLOR,
        K_MODE, K_ROI, K_TMONO, K_TRED, K_TGRN, K_TBLU, K_SPECIAL, K_NONE
    } key_e;

    typedef struct packed {
        logic [1:0]        tmode;
        logic [1:0]        bin;
        logic [GAIN_W-1:0] gain;
        logic [OFS_W-1:0]  ofs;
        logic [1:0]        shut;
        logic [1:0]        dly;
        logic              abl;
        logic              color;
        logic [1:0]        mode;
        logic [ROI_W-1:0]  roi;
        logic [TIME_W-1:0] t_mono;
        logic [TIME_W-1:0] t_red;
        logic [TIME_W-1:0] t_grn;
        logic [TIME_W-1:0] t_blu;
    } cfg_t;

    function automatic key_e decode_key(input logic [7:0] c);
        case (c)
            "T":     return K_TMODE;
            "B":     return K_BIN;
            "G":     return K_GAIN;
            "O":     return K_OFS;
            "S":     return K_SHUT;
            "D":     return K_DLY;
            "A":     return K_ABL;
            "C":     return K_COLOR;
            "M":     return K_MODE;
            "F":     return K_ROI;
            "I":     return K_TMONO;
            "J":     return K_TRED;
            "K":     return K_TGRN;
            "L":     return K_TBLU;
            "!":     return K_SPECIAL;
            default: return K_NONE;
        endcase
    endfunction

    function automatic logic in_range(input key_e k, input logic [15:0] v);
        case (k)
            K_TMODE, K_BIN, K_SHUT, K_MODE: return v <= 16'd2;
            K_DLY:                          return v <= 16'd3;
            K_ABL, K_COLOR:                 return v <= 16'd1;
            K_ROI, K_SPECIAL:               return v <= 16'd5;
            K_OFS:                          return v <= 16'd255;
            K_GAIN:                         return v <= 16'd928;
            K_TMONO, K_TRED, K_TGRN, K_TBLU: return (v >= 16'd1) && (v <= 16'd2000);
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic cfg_t factory_cfg();
        cfg_t c;
        c.tmode  = 2'd0;
        c.bin    = 2'd0;
        c.gain   = GAIN_W'(173);
        c.ofs    = OFS_W'(16);
        c.shut   = 2'd1;
        c.dly    = 2'd2;
        c.abl    = 1'b0;
        c.color  = 1'b0;
        c.mode   = 2'd0;
        c.roi    = '0;
        c.t_mono = TIME_W'(100);
        c.t_red  = TIME_W'(100);
        c.t_grn  = TIME_W'(100);
        c.t_blu  = TIME_W'(100);
        return c;
    endfunction

endpackage

// File: rtl/cfgp_parser.sv
module cfgp_parser
    import cfgp_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             wr_en,
    output key_e             wr_key,
    output logic [ACC_W-1:0] wr_val,
    output logic             restore,
    output logic             ok,
    output logic             err,
    output logic             store_req,
    output logic             query_req,
    output logic [1:0]       query_sel
);
    localparam logic [7:0] CH_CR = 8'd13;
    localparam logic [7:0] CH_EQ = 8'h3D;
    localparam int EXT_W = ACC_W + 4;
    localparam logic [EXT_W-1:0] ACC_MAX = EXT_W'((2 ** ACC_W) - 1);

    typedef enum logic [2:0] {S_IDLE, S_EQ, S_FIRST, S_DIGITS, S_SKIP} st_e;

    st_e              state, state_n;
    key_e             key_q, key_n;
    logic [ACC_W-1:0] acc_q, acc_n;

    logic             wr_en_n, restore_n, ok_n, err_n, store_n, query_n;
    logic [1:0]       qsel_n;

    logic             is_cr, is_digit;
    logic [3:0]       digit;
    logic [EXT_W-1:0] acc_ext, acc_next_ext;
    logic [15:0]      acc16;

    assign is_cr        = (rx_byte == CH_CR);
    assign is_digit     = (rx_byte >= "0") && (rx_byte <= "9");
    assign digit        = rx_byte[3:0];
    assign acc_ext      = EXT_W'(acc_q);
    assign acc_next_ext = (acc_ext << 3) + (acc_ext << 1) + EXT_W'(digit);
    assign acc16        = 16'(acc_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            key_q <= K_NONE;
            acc_q <= '0;
        end else begin
            state <= state_n;
            key_q <= key_n;
            acc_q <= acc_n;
        end
    end

    // next state and next outputs
    always_comb begin
        state_n   = state;
        key_n     = key_q;
        acc_n     = acc_q;
        wr_en_n   = 1'b0;
        restore_n = 1'b0;
        ok_n      = 1'b0;
        err_n     = 1'b0;
        store_n   = 1'b0;
        query_n   = 1'b0;
        qsel_n    = 2'd0;
        if (rx_valid) begin
            unique case (state)
                S_IDLE: begin
                    if (!is_cr) begin
                        key_n   = decode_key(rx_byte);
                        state_n = (decode_key(rx_byte) == K_NONE) ? S_SKIP : S_EQ;
                    end
                end
                S_EQ: begin
                    if (is_cr) begin
                        err_n   = 1'b1;
                        state_n = S_IDLE;
                    end else begin
                        state_n = (rx_byte == CH_EQ) ? S_FIRST : S_SKIP;
                    end
                end
                S_FIRST: begin
                    if (is_cr) begin
                        err_n   = 1'b1;
                        state_n = S_IDLE;
                    end else if (is_digit) begin
                        acc_n   = ACC_W'(digit);
                        state_n = S_DIGITS;
                    end else begin
                        state_n = S_SKIP;
                    end
                end
                S_DIGITS: begin
                    if (is_digit) begin
                        acc_n = (acc_next_ext > ACC_MAX) ? ACC_MAX[ACC_W-1:0]
                                                         : acc_next_ext[ACC_W-1:0];
                    end else if (is_cr) begin
                        state_n = S_IDLE;
                        if (in_range(key_q, acc16)) begin
                            ok_n = 1'b1;
                            if (key_q == K_SPECIAL) begin
                                restore_n = (acc16 == 16'd5);
                                store_n   = (acc16 == 16'd4);
                                query_n   = (acc16 <= 16'd3);
                                qsel_n    = acc_q[1:0];
                            end else begin
                                wr_en_n = 1'b1;
                            end
                        end else begin
                            err_n = 1'b1;
                        end
                    end else begin
                        state_n = S_SKIP;
                    end
                end
                S_SKIP: begin
                    if (is_cr) begin
                        err_n   = 1'b1;
                        state_n = S_IDLE;
                    end
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_key    <= K_NONE;
            wr_val    <= '0;
            restore   <= 1'b0;
            ok        <= 1'b0;
            err       <= 1'b0;
            store_req <= 1'b0;
            query_req <= 1'b0;
            query_sel <= 2'd0;
        end else begin
            wr_en     <= wr_en_n;
            wr_key    <= key_q;
            wr_val    <= acc_q;
            restore   <= restore_n;
            ok        <= ok_n;
            err       <= err_n;
            store_req <= store_n;
            query_req <= query_n;
            query_sel <= qsel_n;
        end
    end

    // R9: accept and reject are exclusive
    a_r9_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));
    // R1: an accept follows a taken CR
    a_r1_ok_after_cr: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> $past(rx_valid && (rx_byte == CH_CR)));
    // R2: a reject follows a taken CR
    a_r2_err_after_cr: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(rx_valid && (rx_byte == CH_CR)));
    // R8: at most one special action per command, each with an accept
    a_r8_special_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({restore, store_req, query_req}) &&
        ((restore || store_req || query_req) -> ok));
    // R3: only in-range values reach the bank
    a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_val <= ACC_W'(2000)) && (wr_key != K_SPECIAL) && ok);

endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
    import cfgp_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  key_e             wr_key,
    input  logic [ACC_W-1:0] wr_val,
    input  logic             restore,
    input  logic             apply,
    output cfg_t             active_o
);
    cfg_t shadow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= factory_cfg();
        end else if (restore) begin
            shadow <= factory_cfg();
        end else if (wr_en) begin
            unique case (wr_key)
                K_TMODE: shadow.tmode  <= wr_val[1:0];
                K_BIN:   shadow.bin    <= wr_val[1:0];
                K_GAIN:  shadow.gain   <= wr_val[GAIN_W-1:0];
                K_OFS:   shadow.ofs    <= wr_val[OFS_W-1:0];
                K_SHUT:  shadow.shut   <= wr_val[1:0];
                K_DLY:   shadow.dly    <= wr_val[1:0];
                K_ABL:   shadow.abl    <= wr_val[0];
                K_COLOR: shadow.color  <= wr_val[0];
                K_MODE:  shadow.mode   <= wr_val[1:0];
                K_ROI:   shadow.roi    <= wr_val[ROI_W-1:0];
                K_TMONO: shadow.t_mono <= wr_val[TIME_W-1:0];
                K_TRED:  shadow.t_red  <= wr_val[TIME_W-1:0];
                K_TGRN:  shadow.t_grn  <= wr_val[TIME_W-1:0];
                K_TBLU:  shadow.t_blu  <= wr_val[TIME_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     active_o <= factory_cfg();
        else if (apply) active_o <= shadow;
    end

    // R2: with no write or restore the shadow bank holds
    a_r2_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !restore) |=> $stable(shadow));
    // R6: active bank moves only on apply
    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(active_o));
    // R6: apply copies the shadow as it stood at the edge
    a_r6_apply_copy: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (active_o == $past(shadow)));
    // R3: stored gain and exposure stay in range
    a_r3_shadow_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow.gain <= GAIN_W'(928)) && (shadow.t_mono != '0) && (shadow.t_blu != '0));

endmodule

// File: rtl/cfg_cmd_parser.sv
module cfg_cmd_parser
    import cfgp_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              apply_pulse,
    output logic              cmd_ok,
    output logic              cmd_err,
    output logic              store_req,
    output logic              query_req,
    output logic [1:0]        query_sel,
    output logic [1:0]        cur_tmode,
    output logic [1:0]        cur_bin,
    output logic [GAIN_W-1:0] cur_gain,
    output logic [OFS_W-1:0]  cur_ofs,
    output logic [1:0]        cur_shut,
    output logic [1:0]        cur_dly,
    output logic              cur_abl,
    output logic              cur_color,
    output logic [1:0]        cur_mode,
    output logic [ROI_W-1:0]  cur_roi,
    output logic [TIME_W-1:0] cur_t_mono,
    output logic [TIME_W-1:0] cur_t_red,
    output logic [TIME_W-1:0] cur_t_grn,
    output logic [TIME_W-1:0] cur_t_blu
);
    logic             wr_en, restore;
    key_e             wr_key;
    logic [ACC_W-1:0] wr_val;
    cfg_t             act;

    cfgp_parser #(.ACC_W(ACC_W)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .wr_en     (wr_en),
        .wr_key    (wr_key),
        .wr_val    (wr_val),
        .restore   (restore),
        .ok        (cmd_ok),
        .err       (cmd_err),
        .store_req (store_req),
        .query_req (query_req),
        .query_sel (query_sel)
    );

    cfgp_bank #(.ACC_W(ACC_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_key   (wr_key),
        .wr_val   (wr_val),
        .restore  (restore),
        .apply    (apply_pulse),
        .active_o (act)
    );

    assign cur_tmode  = act.tmode;
    assign cur_bin    = act.bin;
    assign cur_gain   = act.gain;
    assign cur_ofs    = act.ofs;
    assign cur_shut   = act.shut;
    assign cur_dly    = act.dly;
    assign cur_abl    = act.abl;
    assign cur_color  = act.color;
    assign cur_mode   = act.mode;
    assign cur_roi    = act.roi;
    assign cur_t_mono = act.t_mono;
    assign cur_t_red  = act.t_red;
    assign cur_t_grn  = act.t_grn;
    assign cur_t_blu  = act.t_blu;

endmodule

// File: tb/tb_cfg_cmd_parser.sv
module tb_cfg_cmd_parser;
    localparam int EV_OK = 0, EV_ERR = 1, EV_STORE = 2, EV_QRY = 3;

    logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0, apply_pulse = 1'b0;
    logic [7:0] rx_byte = 8'd0;
    logic cmd_ok, cmd_err, store_req, query_req, cur_abl, cur_color;
    logic [1:0] query_sel, cur_tmode, cur_bin, cur_shut, cur_dly, cur_mode;
    logic [9:0] cur_gain;
    logic [7:0] cur_ofs;
    logic [2:0] cur_roi;
    logic [10:0] cur_t_mono, cur_t_red, cur_t_grn, cur_t_blu;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    cfg_cmd_parser dut (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'hFF;
    endtask

    // driver: queue the expected result, then send the command and CR
    task automatic send_cmd(string s, int ev, string tag);
        exp_q.push_back(ev);
        tag_q.push_back(tag);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        send_byte(8'd13);
        repeat (2) @(negedge clk);
    endtask

    task automatic apply();
        @(negedge clk);
        apply_pulse = 1'b1;
        @(negedge clk);
        apply_pulse = 1'b0;
    endtask

    // monitor: pop and compare each strobe
    always @(negedge clk) begin
        if (rst_n && (cmd_ok || cmd_err)) begin
            int obs;
            if (cmd_ok && cmd_err) obs = 99;
            else if (cmd_err)      obs = EV_ERR;
            else if (store_req)    obs = EV_STORE;
            else if (query_req)    obs = EV_QRY + int'(query_sel);
            else                   obs = EV_OK;
            if (exp_q.size() == 0) begin
                check("R10 unexpected strobe", obs, -1);
            end else begin
                check(tag_q.pop_front(), obs, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        check("R5 gain", cur_gain, 173);
        check("R5 ofs", cur_ofs, 16);
        check("R5 shut", cur_shut, 1);
        check("R5 dly", cur_dly, 2);
        check("R5 t_mono", cur_t_mono, 100);
        check("R5 t_blu", cur_t_blu, 100);
        check("R5 tmode", cur_tmode, 0);

        // R1 / R6 deferred apply
        send_cmd("G=500", EV_OK, "R1 G=500");
        check("R6 gain before apply", cur_gain, 173);
        apply();
        check("R6 gain after apply", cur_gain, 500);

        // R4 leading zeros
        send_cmd("O=0255", EV_OK, "R4 leading zeros");
        send_cmd("J=0007", EV_OK, "R4 J=0007");
        apply();
        check("R4 ofs", cur_ofs, 255);
        check("R4 t_red", cur_t_red, 7);

        // R3 ranges
        send_cmd("I=3000", EV_ERR, "R3 I=3000");
        send_cmd("I=0", EV_ERR, "R3 I=0");
        send_cmd("G=929", EV_ERR, "R3 G=929");
        send_cmd("D=4", EV_ERR, "R3 D=4");
        apply();
        check("R3 t_mono kept", cur_t_mono, 100);
        check("R3 gain kept", cur_gain, 500);
        check("R3 dly kept", cur_dly, 2);
        send_cmd("I=2000", EV_OK, "R3 I=2000");
        send_cmd("G=928", EV_OK, "R3 G=928");
        send_cmd("F=5", EV_OK, "R3 F=5");
        apply();
        check("R3 t_mono max", cur_t_mono, 2000);
        check("R3 gain max", cur_gain, 928);
        check("R3 roi", cur_roi, 5);

        // R4 saturation
        send_cmd("A=99999999", EV_ERR, "R4 saturate");
        send_cmd("O=65536", EV_ERR, "R4 wrap guard");
        apply();
        check("R4 abl kept", cur_abl, 0);
        check("R4 ofs kept", cur_ofs, 255);

        // R2 syntax errors and resync
        send_cmd("i=5", EV_ERR, "R2 lowercase");
        send_cmd("G =5", EV_ERR, "R2 space");
        send_cmd("G=1\t", EV_ERR, "R2 tab");
        send_cmd("G=", EV_ERR, "R2 no digits");
        send_cmd("G5", EV_ERR, "R2 no equals");
        send_cmd("Y=4", EV_ERR, "R2 unknown key");
        send_cmd("T", EV_ERR, "R2 key only");
        send_cmd("T=2", EV_OK, "R2 resync");
        apply();
        check("R2 gain kept", cur_gain, 928);
        check("R2 tmode resync", cur_tmode, 2);

        // R10 bare CR
        send_byte(8'd13);
        repeat (3) @(negedge clk);

        // R9 bytes without valid are ignored
        rx_byte = "X";
        repeat (3) @(negedge clk);
        rx_byte = 8'd13;
        repeat (3) @(negedge clk);
        send_cmd("C=1", EV_OK, "R9 after idle bytes");
        apply();
        check("R9 color", cur_color, 1);

        // R6 apply coinciding with shadow write
        exp_q.push_back(EV_OK);
        tag_q.push_back("R6 O=7");
        send_byte("O"); send_byte("="); send_byte("7"); send_byte(8'd13);
        apply_pulse = 1'b1;
        @(negedge clk);
        apply_pulse = 1'b0;
        check("R6 same-cycle apply keeps old", cur_ofs, 255);
        apply();
        check("R6 next apply", cur_ofs, 7);

        // R7 restore
        send_cmd("!=5", EV_OK, "R7 restore");
        check("R7 active untouched", cur_gain, 928);
        apply();
        check("R7 gain default", cur_gain, 173);
        check("R7 t_mono default", cur_t_mono, 100);
        check("R7 color default", cur_color, 0);

        // R8 special commands
        send_cmd("!=4", EV_STORE, "R8 store");
        send_cmd("!=2", EV_QRY + 2, "R8 query 2");
        send_cmd("!=0", EV_QRY, "R8 query 0");
        send_cmd("!=6", EV_ERR, "R8 !=6");

        repeat (4) @(negedge clk);
        check("R1 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule